// File: doc/BRIEF.md
# Next-Interrupt CSR Access Unit

This block serves the read-modify-write accesses that software makes to the two "next interrupt" control registers of a core-local interrupt controller. There is one for machine mode and one for supervisor mode. An interrupt handler reads or writes one of these registers to find out whether a further interrupt of its own privilege is waiting at a higher level than the context it saved. If one is waiting, the access returns a pointer into the trap-vector table, and a write access also claims that interrupt. Software can then take the next handler without a trap return and a fresh trap entry.

The core presents one access per cycle on `acc_valid`, together with the register address, the write mask and the write data. It also drives the current privilege, the cause, threshold and vector-table-base registers of both modes, and the descriptor of the winning pending interrupt. Read data and the illegal-access flag are combinational from the current inputs. All register updates that one access causes leave the block as strobes registered on the clock edge that ends the access. The core then applies them together.

The block accepts an access on every cycle and has no back-pressure, so no ready signal exists. An access without `acc_valid`, or to any other address, has no effect. Privilege encoding on `cur_priv` and `irq_priv` is 2'b11 machine, 2'b01 supervisor and 2'b00 user.

Top module: `nxti_csr_unit`

## Requirements
- R1: Only an access with `acc_valid` high to address 12'h345 (machine register) or 12'h145 (supervisor register) is served. Any other access returns `rdata` 0 and produces no update strobe on the following cycle.
- R2: An access to 12'h345 is illegal unless `cur_priv` is 2'b11. An access to 12'h145 is illegal unless `cur_priv` is 2'b11 or 2'b01. An illegal access raises `illegal` in the same cycle, returns `rdata` 0 and produces no strobe on the next cycle.
- R3: An interrupt qualifies only when `irq_code` is nonzero, `clic_mode` is high, `irq_priv` equals `cur_priv` and `irq_hw_vec` is low.
- R4: An interrupt qualifies only when `irq_level` is strictly greater than the larger of two values: bits [23:16] of the addressed mode's cause register (`mcause_q` or `scause_q`) and that mode's threshold (`mthresh_q` or `sthresh_q`).
- R5: While an interrupt qualifies, `rdata` equals the addressed mode's vector base (`mtvt_q` or `stvt_q`) with bits [5:0] cleared, plus `irq_code` times XLEN/8. Otherwise `rdata` is 0. It is combinational in the cycle of the access.
- R6: A legal access with nonzero `acc_wmask` raises `st_or_en` on the next cycle, with `st_or_bits` = `acc_wdata & acc_wmask` bits [4:0]. This happens whether or not an interrupt qualifies.
- R7: A legal write that qualifies raises `ist_we` and `cause_we` together on the next cycle. `ist_lane` is the interrupt-status byte index (3 for machine, bits [31:24]; 1 for supervisor, bits [15:8]), `ist_level` = `irq_level`, `cause_sel_s` = 1 for supervisor, and `cause_code` = `irq_code`, which is the value for cause bits [11:0].
- R8: A qualifying write whose interrupt has `irq_edge` high raises `pend_clr` with `pend_clr_id` = `irq_code` on the next cycle. A level-triggered one (`irq_edge` low) raises no clear.
- R9: An access with `acc_wmask` zero (read only) produces no update strobe.
- R10: During and straight after reset all strobes are low.
- R11: Every strobe lasts one cycle. It drops on the next cycle unless another access raises it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| acc_valid | input | 1 | CSR access present this cycle |
| acc_addr | input | 12 | CSR address |
| acc_wmask | input | XLEN | write mask, zero for a read-only access |
| acc_wdata | input | XLEN | write data |
| cur_priv | input | 2 | current privilege |
| clic_mode | input | 1 | controller operates in CLIC mode |
| mcause_q | input | XLEN | machine cause register |
| scause_q | input | XLEN | supervisor cause register |
| mthresh_q | input | 8 | machine interrupt threshold |
| sthresh_q | input | 8 | supervisor interrupt threshold |
| mtvt_q | input | XLEN | machine vector-table base |
| stvt_q | input | XLEN | supervisor vector-table base |
| irq_code | input | 12 | winning interrupt id, 0 = none pending |
| irq_priv | input | 2 | winning interrupt privilege |
| irq_level | input | 8 | winning interrupt level |
| irq_edge | input | 1 | winning interrupt is edge-triggered |
| irq_hw_vec | input | 1 | winning interrupt is hardware-vectored |
| rdata | output | XLEN | read data (table pointer or 0) |
| illegal | output | 1 | illegal-instruction indication |
| st_or_en | output | 1 | OR `st_or_bits` into the status register |
| st_or_bits | output | 5 | bits to OR into status [4:0] |
| ist_we | output | 1 | write interrupt-status level byte |
| ist_lane | output | 2 | byte index within interrupt-status |
| ist_level | output | 8 | level to write |
| cause_we | output | 1 | write cause exception-code field |
| cause_sel_s | output | 1 | 1 = supervisor cause, 0 = machine cause |
| cause_code | output | 12 | value for cause [11:0] |
| pend_clr | output | 1 | clear pending bit of an interrupt |
| pend_clr_id | output | 12 | id of the interrupt to clear |

## Verification
The assertions check on every cycle that an illegal or unaddressed access is followed by no strobe. They also check that a claim or a status update always follows a write access one cycle earlier, that a pending clear never appears without a claim, that a claimed level lies above the threshold in force at the time of the access, and that a user-mode access reads zero. Only the bench's scenarios can show the exact pointer arithmetic and the strict boundary at equal level. The same holds for the separate roles of the saved level and the threshold, for level-triggered interrupts not being cleared, for hardware-vectored interrupts not being claimed, and for a read-only access leaving everything untouched.

// File: rtl/nxti_pkg.sv
package nxti_pkg;
  localparam logic [11:0] ADDR_M_NXT = 12'h345;
  localparam logic [11:0] ADDR_S_NXT = 12'h145;
  localparam logic [1:0]  PRIV_U     = 2'b00;
  localparam logic [1:0]  PRIV_S     = 2'b01;
  localparam logic [1:0]  PRIV_M     = 2'b11;
  localparam int          LVL_W      = 8;
  localparam int          CODE_W     = 12;
  localparam int          PIL_LSB    = 16;
  localparam int          ST_BITS    = 5;
  localparam int          TVT_ALIGN  = 6;
  localparam logic [1:0]  LANE_M     = 2'd3;
  localparam logic [1:0]  LANE_S     = 2'd1;
endpackage

// File: rtl/nxti_sel.sv
module nxti_sel
  import nxti_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              acc_valid,
  input  logic [11:0]       acc_addr,
  input  logic [1:0]        cur_priv,
  input  logic [XLEN-1:0]   mcause_q,
  input  logic [XLEN-1:0]   scause_q,
  input  logic [LVL_W-1:0]  mthresh_q,
  input  logic [LVL_W-1:0]  sthresh_q,
  input  logic [XLEN-1:0]   mtvt_q,
  input  logic [XLEN-1:0]   stvt_q,
  output logic              sel_hit,
  output logic              sel_s,
  output logic              illegal,
  output logic [LVL_W-1:0]  sel_pil,
  output logic [LVL_W-1:0]  sel_thr,
  output logic [XLEN-1:0]   sel_tvt
);
  logic hit_m, hit_s, priv_ok;

  always_comb begin
    hit_m   = acc_valid && (acc_addr == ADDR_M_NXT);
    hit_s   = acc_valid && (acc_addr == ADDR_S_NXT);
    // machine register needs machine privilege; supervisor register needs S or M
    priv_ok = (cur_priv == PRIV_M) || (hit_s && cur_priv == PRIV_S);
    illegal = (hit_m || hit_s) && !priv_ok;
    sel_hit = (hit_m || hit_s) && priv_ok;
    sel_s   = hit_s;
    sel_pil = hit_s ? scause_q[PIL_LSB +: LVL_W] : mcause_q[PIL_LSB +: LVL_W];
    sel_thr = hit_s ? sthresh_q : mthresh_q;
    sel_tvt = hit_s ? stvt_q : mtvt_q;
  end
endmodule

// File: rtl/nxti_qual.sv
module nxti_qual
  import nxti_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              sel_hit,
  input  logic [LVL_W-1:0]  sel_pil,
  input  logic [LVL_W-1:0]  sel_thr,
  input  logic [XLEN-1:0]   sel_tvt,
  input  logic              clic_mode,
  input  logic [1:0]        cur_priv,
  input  logic [CODE_W-1:0] irq_code,
  input  logic [1:0]        irq_priv,
  input  logic [LVL_W-1:0]  irq_level,
  input  logic              irq_hw_vec,
  output logic              qual,
  output logic [XLEN-1:0]   rdata
);
  localparam int ENTRY_SH = $clog2(XLEN / 8);

  logic [LVL_W-1:0] floor_lvl;
  logic [XLEN-1:0]  base, offs;

  always_comb begin
    floor_lvl = (sel_pil > sel_thr) ? sel_pil : sel_thr;
    qual = sel_hit && (irq_code != '0) && clic_mode && (irq_priv == cur_priv)
           && !irq_hw_vec && (irq_level > floor_lvl);
    base  = {sel_tvt[XLEN-1:TVT_ALIGN], {TVT_ALIGN{1'b0}}};
    offs  = XLEN'(irq_code) << ENTRY_SH;
    rdata = qual ? (base + offs) : '0;
  end
endmodule

// File: rtl/nxti_upd.sv
module nxti_upd
  import nxti_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_hit,
  input  logic              sel_s,
  input  logic              wr,
  input  logic [ST_BITS-1:0] wbits,
  input  logic              qual,
  input  logic [LVL_W-1:0]  irq_level,
  input  logic [CODE_W-1:0] irq_code,
  input  logic              irq_edge,
  output logic              st_or_en,
  output logic [ST_BITS-1:0] st_or_bits,
  output logic              ist_we,
  output logic [1:0]        ist_lane,
  output logic [LVL_W-1:0]  ist_level,
  output logic              cause_we,
  output logic              cause_sel_s,
  output logic [CODE_W-1:0] cause_code,
  output logic              pend_clr,
  output logic [CODE_W-1:0] pend_clr_id
);
  logic do_wr, claim;

  always_comb begin
    do_wr = sel_hit && wr;
    claim = do_wr && qual;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_or_en    <= 1'b0;
      st_or_bits  <= '0;
      ist_we      <= 1'b0;
      ist_lane    <= '0;
      ist_level   <= '0;
      cause_we    <= 1'b0;
      cause_sel_s <= 1'b0;
      cause_code  <= '0;
      pend_clr    <= 1'b0;
      pend_clr_id <= '0;
    end else begin
      st_or_en    <= do_wr;
      st_or_bits  <= do_wr ? wbits : '0;
      ist_we      <= claim;
      cause_we    <= claim;
      pend_clr    <= claim && irq_edge;
      if (claim) begin
        ist_lane    <= sel_s ? LANE_S : LANE_M;
        ist_level   <= irq_level;
        cause_sel_s <= sel_s;
        cause_code  <= irq_code;
      end
      if (claim && irq_edge) pend_clr_id <= irq_code;
    end
  end

  // R8: a pending clear only accompanies a claim
  p_clr_with_claim_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pend_clr |-> cause_we && ist_we);
  // R9: a read-only access leaves no strobe behind
  p_read_only_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_hit && !wr) |=> !st_or_en && !ist_we && !pend_clr);
endmodule

// File: rtl/nxti_csr_unit.sv
module nxti_csr_unit
  import nxti_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [11:0]       acc_addr,
  input  logic [XLEN-1:0]   acc_wmask,
  input  logic [XLEN-1:0]   acc_wdata,
  input  logic [1:0]        cur_priv,
  input  logic              clic_mode,
  input  logic [XLEN-1:0]   mcause_q,
  input  logic [XLEN-1:0]   scause_q,
  input  logic [7:0]        mthresh_q,
  input  logic [7:0]        sthresh_q,
  input  logic [XLEN-1:0]   mtvt_q,
  input  logic [XLEN-1:0]   stvt_q,
  input  logic [11:0]       irq_code,
  input  logic [1:0]        irq_priv,
  input  logic [7:0]        irq_level,
  input  logic              irq_edge,
  input  logic              irq_hw_vec,
  output logic [XLEN-1:0]   rdata,
  output logic              illegal,
  output logic              st_or_en,
  output logic [4:0]        st_or_bits,
  output logic              ist_we,
  output logic [1:0]        ist_lane,
  output logic [7:0]        ist_level,
  output logic              cause_we,
  output logic              cause_sel_s,
  output logic [11:0]       cause_code,
  output logic              pend_clr,
  output logic [11:0]       pend_clr_id
);
  logic             sel_hit, sel_s, qual, wr;
  logic [LVL_W-1:0] sel_pil, sel_thr;
  logic [XLEN-1:0]  sel_tvt;
  logic [ST_BITS-1:0] wbits;

  always_comb begin
    wr    = (acc_wmask != '0);
    wbits = acc_wdata[ST_BITS-1:0] & acc_wmask[ST_BITS-1:0];
  end

  nxti_sel #(.XLEN(XLEN)) i_sel (
    .acc_valid(acc_valid), .acc_addr(acc_addr), .cur_priv(cur_priv),
    .mcause_q(mcause_q), .scause_q(scause_q), .mthresh_q(mthresh_q),
    .sthresh_q(sthresh_q), .mtvt_q(mtvt_q), .stvt_q(stvt_q),
    .sel_hit(sel_hit), .sel_s(sel_s), .illegal(illegal),
    .sel_pil(sel_pil), .sel_thr(sel_thr), .sel_tvt(sel_tvt)
  );

  nxti_qual #(.XLEN(XLEN)) i_qual (
    .sel_hit(sel_hit), .sel_pil(sel_pil), .sel_thr(sel_thr), .sel_tvt(sel_tvt),
    .clic_mode(clic_mode), .cur_priv(cur_priv), .irq_code(irq_code),
    .irq_priv(irq_priv), .irq_level(irq_level), .irq_hw_vec(irq_hw_vec),
    .qual(qual), .rdata(rdata)
  );

  nxti_upd i_upd (
    .clk(clk), .rst_n(rst_n), .sel_hit(sel_hit), .sel_s(sel_s), .wr(wr),
    .wbits(wbits), .qual(qual), .irq_level(irq_level), .irq_code(irq_code),
    .irq_edge(irq_edge), .st_or_en(st_or_en), .st_or_bits(st_or_bits),
    .ist_we(ist_we), .ist_lane(ist_lane), .ist_level(ist_level),
    .cause_we(cause_we), .cause_sel_s(cause_sel_s), .cause_code(cause_code),
    .pend_clr(pend_clr), .pend_clr_id(pend_clr_id)
  );

  // R2: an illegal access updates nothing
  p_illegal_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> !st_or_en && !ist_we && !cause_we && !pend_clr);
  // R2: user privilege never reads a pointer
  p_user_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && cur_priv == PRIV_U) |-> rdata == '0);
  // R1: other addresses leave no strobe
  p_other_addr_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_addr != ADDR_M_NXT && acc_addr != ADDR_S_NXT) |=> !st_or_en && !cause_we);
  // R7: a claim follows a write access
  p_claim_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_we || ist_we) |-> $past(acc_valid && acc_wmask != '0));
  // R4: a claimed machine level lies above the machine threshold
  p_level_above_thr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_we && !cause_sel_s) |-> ist_level > $past(mthresh_q));
endmodule

// File: tb/test_nxti_csr_unit.sv
module test_nxti_csr_unit;
  localparam int XLEN = 32;
  localparam time CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic acc_valid = 0;
  logic [11:0] acc_addr = 0;
  logic [XLEN-1:0] acc_wmask = 0, acc_wdata = 0;
  logic [1:0] cur_priv = 2'b11;
  logic clic_mode = 1;
  logic [XLEN-1:0] mcause_q = 0, scause_q = 0, mtvt_q = 0, stvt_q = 0;
  logic [7:0] mthresh_q = 0, sthresh_q = 0;
  logic [11:0] irq_code = 0;
  logic [1:0] irq_priv = 2'b11;
  logic [7:0] irq_level = 0;
  logic irq_edge = 0, irq_hw_vec = 0;
  logic [XLEN-1:0] rdata;
  logic illegal, st_or_en, ist_we, cause_we, cause_sel_s, pend_clr;
  logic [4:0] st_or_bits;
  logic [1:0] ist_lane;
  logic [7:0] ist_level;
  logic [11:0] cause_code, pend_clr_id;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nxti_csr_unit #(.XLEN(XLEN)) i_nxti_csr_unit (.*);

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Apply one access at a negedge; returns rdata/illegal in the access cycle.
  // Strobes are sampled at the following negedge, then one cycle later.
  logic [XLEN-1:0] got_rdata;
  logic got_ill;
  task automatic access(input logic [11:0] a, input logic [XLEN-1:0] m, input logic [XLEN-1:0] d);
    @(negedge clk);
    acc_valid = 1; acc_addr = a; acc_wmask = m; acc_wdata = d;
    #1;
    got_rdata = rdata; got_ill = illegal;
    @(negedge clk);
    acc_valid = 0; acc_addr = 0; acc_wmask = 0; acc_wdata = 0;
  endtask

  task automatic chk_quiet(input string req);
    chk(req, "st_or_en", st_or_en, 0);
    chk(req, "ist_we", ist_we, 0);
    chk(req, "cause_we", cause_we, 0);
    chk(req, "pend_clr", pend_clr, 0);
  endtask

  task automatic setup_m();
    cur_priv = 2'b11; clic_mode = 1; irq_priv = 2'b11; irq_code = 12'd5;
    irq_level = 8'h40; irq_edge = 1; irq_hw_vec = 0;
    mcause_q = 32'h0010_0000; mthresh_q = 8'h20; mtvt_q = 32'h8000_0047;
  endtask

  task automatic t_reset();
    chk_quiet("R10");
  endtask

  task automatic t_m_claim_edge();
    setup_m();
    access(12'h345, 32'hFF, 32'h0000_003A);
    chk("R5", "rdata", got_rdata, 32'h8000_0054);
    chk("R6", "st_or_en", st_or_en, 1);
    chk("R6", "st_or_bits", st_or_bits, 5'h1A);
    chk("R7", "ist_we", ist_we, 1);
    chk("R7", "ist_lane", ist_lane, 3);
    chk("R7", "ist_level", ist_level, 8'h40);
    chk("R7", "cause_we", cause_we, 1);
    chk("R7", "cause_sel_s", cause_sel_s, 0);
    chk("R7", "cause_code", cause_code, 12'd5);
    chk("R8", "pend_clr", pend_clr, 1);
    chk("R8", "pend_clr_id", pend_clr_id, 12'd5);
    @(negedge clk);
    chk_quiet("R11");
  endtask

  task automatic t_level_trig();
    setup_m(); irq_edge = 0;
    access(12'h345, 32'h1, 32'h0);
    chk("R8", "cause_we level-trig", cause_we, 1);
    chk("R8", "pend_clr level-trig", pend_clr, 0);
  endtask

  task automatic t_equal_thresh();
    setup_m(); irq_level = 8'h20;
    access(12'h345, 32'h1F, 32'h3);
    chk("R4", "rdata equal level", got_rdata, 0);
    chk("R4", "ist_we equal level", ist_we, 0);
    chk("R6", "st_or_en no qual", st_or_en, 1);
    chk("R6", "st_or_bits no qual", st_or_bits, 5'h3);
  endtask

  task automatic t_below_saved();
    setup_m(); mcause_q = 32'h0050_0000;
    access(12'h345, 32'h1, 32'h0);
    chk("R4", "rdata below saved", got_rdata, 0);
    chk("R4", "cause_we below saved", cause_we, 0);
  endtask

  task automatic t_hw_vec();
    setup_m(); irq_hw_vec = 1;
    access(12'h345, 32'h1, 32'h0);
    chk("R3", "rdata hw-vectored", got_rdata, 0);
    chk("R3", "pend_clr hw-vectored", pend_clr, 0);
  endtask

  task automatic t_other_gates();
    setup_m(); irq_priv = 2'b01;
    access(12'h345, 32'h0, 32'h0);
    chk("R3", "rdata priv mismatch", got_rdata, 0);
    setup_m(); clic_mode = 0;
    access(12'h345, 32'h0, 32'h0);
    chk("R3", "rdata not clic", got_rdata, 0);
    setup_m(); irq_code = 0;
    access(12'h345, 32'h0, 32'h0);
    chk("R3", "rdata no pending", got_rdata, 0);
  endtask

  task automatic t_read_only();
    setup_m();
    access(12'h345, 32'h0, 32'hFFFF_FFFF);
    chk("R9", "rdata read-only", got_rdata, 32'h8000_0054);
    chk_quiet("R9");
  endtask

  task automatic t_s_claim();
    setup_m();
    cur_priv = 2'b01; irq_priv = 2'b01; irq_code = 12'd9; irq_level = 8'h07;
    scause_q = 32'h0003_0000; sthresh_q = 8'h01; stvt_q = 32'h0000_1000;
    mthresh_q = 8'hFF;
    access(12'h145, 32'h2, 32'h2);
    chk("R5", "rdata S", got_rdata, 32'h0000_1024);
    chk("R7", "ist_lane S", ist_lane, 1);
    chk("R7", "cause_sel_s S", cause_sel_s, 1);
    chk("R7", "cause_code S", cause_code, 12'd9);
    chk("R4", "ist_level S", ist_level, 8'h07);
  endtask

  task automatic t_illegal();
    setup_m(); cur_priv = 2'b00; irq_priv = 2'b00;
    access(12'h145, 32'h1F, 32'h1F);
    chk("R2", "illegal user", got_ill, 1);
    chk("R2", "rdata user", got_rdata, 0);
    chk_quiet("R2");
    setup_m(); cur_priv = 2'b01; irq_priv = 2'b01;
    access(12'h345, 32'h1F, 32'h1F);
    chk("R2", "illegal M from S", got_ill, 1);
    chk_quiet("R2");
  endtask

  task automatic t_other_addr();
    setup_m();
    access(12'h344, 32'h1F, 32'h1F);
    chk("R1", "rdata other addr", got_rdata, 0);
    chk("R1", "illegal other addr", got_ill, 0);
    chk_quiet("R1");
  endtask

  initial begin
    fork
      begin
        #(CLK_PERIOD * 3);
        @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_m_claim_edge();
        t_level_trig();
        t_equal_thresh();
        t_below_saved();
        t_hw_vec();
        t_other_gates();
        t_read_only();
        t_s_claim();
        t_illegal();
        t_other_addr();
      end
      begin
        #(CLK_PERIOD * 5000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule